// File: doc/BRIEF.md
# Parity-Generating Asynchronous Serial Transmitter

This block turns words written by a host into asynchronous serial frames on a single line. A frame is a low start bit, the payload sent least significant bit first, and a high stop bit. Each bit lasts a fixed number of baud ticks. The baud ticks come from a rate generator outside the block, and the line rests high between frames. A one-word holding buffer sits in front of the shift register. The host can therefore queue the next word while the current frame is still on the line. That word then follows with no idle gap.

Parity is worked out once, at the moment the host writes. The format, parity-enable and odd/even inputs are sampled on that write, and the encoded word is stored together with its bit count. In 7-bit format the parity bit replaces host bit 7. In 8-bit format it becomes a ninth payload bit. In the raw 8-bit format parity is never added. At the end of every frame the block raises a one-cycle interrupt pulse.

The sequencer has four states. IDLE holds the line high. START drives the start bit. DATA shifts out the payload. STOP drives the stop bit. Transitions:
- IDLE→START when the buffer holds a word, which is moved into the shifter.
- START→DATA when the start bit's last tick arrives.
- DATA→DATA on each bit boundary.
- DATA→STOP on the boundary of the last payload bit.
- STOP→START when a word is waiting at the end of the stop bit.
- STOP→IDLE when no word is waiting at the end of the stop bit.

Top module: `uart_tx_par`

## Requirements
- R1: During and right after reset, `txd` is 1, `buf_empty` is 1 and `tx_irq` is 0.
- R2: A frame is one start bit at 0, the payload least significant bit first, and one stop bit at 1. Every bit lasts exactly 16 `baud_tick` pulses, and cycles without a tick do not advance the frame.
- R3: With `cfg_fmt` = 2'b00 (7-bit), the payload is `wr_data[6:0]`, and the written `wr_data[7]` never reaches the line. With parity enabled, the parity bit is sent as an eighth payload bit.
- R4: With `cfg_fmt` = 2'b01 (8-bit), the payload is `wr_data[7:0]`. With parity enabled, the parity bit is sent as a ninth payload bit.
- R5: With `cfg_fmt` = 2'b10 or 2'b11 (raw 8-bit), the payload is `wr_data[7:0]` and `cfg_par_en` has no effect.
- R6: With `cfg_par_odd` = 0, the parity bit is the XOR of the payload data bits (even parity). With `cfg_par_odd` = 1, it is the inverse of that XOR (odd parity).
- R7: `cfg_fmt`, `cfg_par_en` and `cfg_par_odd` are sampled on the write cycle. Changes after the write do not alter that word's frame.
- R8: `tx_irq` is high for exactly one cycle per frame. That cycle follows the clock edge that ends the stop bit.
- R9: `buf_empty` falls in the cycle after a write that the buffer accepts. On an idle line the word is moved into the shifter at the next edge, so `buf_empty` rises again and the start bit begins at that same edge. A word written during a frame is held, with `buf_empty` low, until the current stop bit ends. Its start bit then begins in the same cycle as the `tx_irq` pulse.
- R10: A write while the buffer already holds a waiting word is dropped. The waiting word is sent unchanged, and no extra frame follows it.
- R11: While no frame is in progress, `txd` stays 1 and `tx_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one word per cycle high |
| wr_data | input | 8 | Host write data |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| cfg_fmt | input | 2 | 00 = 7-bit, 01 = 8-bit, 1x = raw 8-bit |
| cfg_par_en | input | 1 | Add a parity bit (7-bit and 8-bit formats only) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding buffer has no waiting word |
| tx_irq | output | 1 | One-cycle pulse at the end of each frame |

## Verification
Two events can land on the same clock edge: the end of a stop bit, which raises the interrupt, and the hand-off of a waiting word into the shifter, which starts the next frame. The bench provokes this by writing a second word, and then a third, while the first frame is only a couple of cycles old. It then checks that the interrupt cycle is also the first start-bit cycle of the second frame, with no high gap between them. It also checks that the third word is dropped: the second frame must match its own word exactly, and the line must stay quiet afterwards.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int SYM_W  = 9;   // widest payload: 8 data bits plus parity
    localparam int CNT_W  = 4;   // holds a payload length up to 9

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        FMT_SEVEN = 2'b00,
        FMT_EIGHT = 2'b01,
        FMT_RAW_A = 2'b10,
        FMT_RAW_B = 2'b11
    } tx_fmt_e;

    typedef struct packed {
        logic [SYM_W-1:0] bits;   // payload, bit 0 goes out first
        logic [CNT_W-1:0] nbits;  // number of payload bits to send
    } tx_word_t;

endpackage

// File: rtl/uart_tx_encoder.sv
module uart_tx_encoder
    import uart_tx_pkg::*;
(
    input  logic [7:0] host_data,
    input  logic [1:0] fmt,
    input  logic       par_en,
    input  logic       par_odd,
    output tx_word_t   word
);

    tx_fmt_e fmt_e;
    logic    par7;
    logic    par8;

    assign fmt_e = tx_fmt_e'(fmt);

    always_comb begin
        par7 = (^host_data[6:0]) ^ par_odd;
        par8 = (^host_data[7:0]) ^ par_odd;
        word = '0;
        unique case (fmt_e)
            FMT_SEVEN: begin
                word.bits  = {2'b00, host_data[6:0]};
                word.nbits = CNT_W'(7);
                if (par_en) begin
                    word.bits[7] = par7;
                    word.nbits   = CNT_W'(8);
                end
            end
            FMT_EIGHT: begin
                word.bits  = {1'b0, host_data};
                word.nbits = CNT_W'(8);
                if (par_en) begin
                    word.bits[8] = par8;
                    word.nbits   = CNT_W'(9);
                end
            end
            default: begin
                word.bits  = {1'b0, host_data};
                word.nbits = CNT_W'(8);
            end
        endcase
    end

    // R6: the encoded payload carries the requested overall parity
    always_comb begin
        if (!$isunknown({host_data, fmt, par_en, par_odd}) && par_en) begin
            if (fmt_e == FMT_SEVEN)
                assert_parity7_R6: assert ((^word.bits[7:0]) == par_odd);
            if (fmt_e == FMT_EIGHT)
                assert_parity8_R6: assert ((^word.bits[8:0]) == par_odd);
        end
    end

endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf
    import uart_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  tx_word_t word_in,
    input  logic     pop,
    output logic     valid,
    output tx_word_t word_out
);

    logic accept;

    assign accept = push && (!valid || pop);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            word_out <= '0;
        end else begin
            valid <= accept || (valid && !pop);
            if (accept)
                word_out <= word_in;
        end
    end

    // R10: a write into an occupied buffer that is not draining leaves it unchanged
    assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop && push) |=> (valid && $stable(word_out)));

endmodule

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);

    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_BIT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign bit_end = run && tick && (cnt == LAST);

    // R2: the bit timer only moves on a baud tick
    assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     buf_valid,
    input  tx_word_t buf_word,
    input  logic     bit_end,
    output logic     pop,
    output logic     run,
    output logic     txd,
    output logic     irq
);

    tx_state_e        state, state_n;
    logic [SYM_W-1:0] shreg;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] nb;
    logic             last_bit;

    assign last_bit = (idx == nb - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // next state and buffer hand-off
    always_comb begin
        state_n = state;
        pop     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (buf_valid) begin
                    state_n = ST_START;
                    pop     = 1'b1;
                end
            end
            ST_START: begin
                if (bit_end)
                    state_n = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && last_bit)
                    state_n = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (buf_valid) begin
                        state_n = ST_START;
                        pop     = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // shifter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            nb    <= '0;
        end else if (pop) begin
            shreg <= buf_word.bits;
            nb    <= buf_word.nbits;
            idx   <= '0;
        end else if (state == ST_DATA && bit_end) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= (state == ST_STOP) && bit_end;
    end

    always_comb begin
        run = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:  txd = 1'b1;
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_STOP:  txd = 1'b1;
        endcase
    end

    // R8: the end-of-frame interrupt never lasts two cycles
    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: a start bit only begins on a hand-off from the buffer
    assert_start_from_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |-> $past(pop));

    // R4: the stop bit follows exactly the stored number of payload bits
    assert_payload_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && $past(state) == ST_DATA) |-> ($past(idx) == $past(nb) - 1'b1));

    // R11: the line is high whenever no frame is running
    assert_idle_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (txd && !irq));

endmodule

// File: rtl/uart_tx_par.sv
module uart_tx_par
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       baud_tick,
    input  logic [1:0] cfg_fmt,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       txd,
    output logic       buf_empty,
    output logic       tx_irq
);

    tx_word_t enc_word;
    tx_word_t held_word;
    logic     held_valid;
    logic     pop;
    logic     run;
    logic     bit_end;

    uart_tx_encoder u_enc (
        .host_data (wr_data),
        .fmt       (cfg_fmt),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .word      (enc_word)
    );

    uart_tx_holdbuf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_en),
        .word_in  (enc_word),
        .pop      (pop),
        .valid    (held_valid),
        .word_out (held_word)
    );

    uart_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    uart_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_valid (held_valid),
        .buf_word  (held_word),
        .bit_end   (bit_end),
        .pop       (pop),
        .run       (run),
        .txd       (txd),
        .irq       (tx_irq)
    );

    assign buf_empty = !held_valid;

    // R9: an accepted write on an empty buffer is seen as non-empty next cycle
    assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_empty) |=> !buf_empty);

endmodule

// File: tb/test_uart_tx_par.sv
module test_uart_tx_par;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b1;
    logic [1:0] cfg_fmt = 2'b00;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       txd;
    logic       buf_empty;
    logic       tx_irq;

    logic slow = 1'b0;
    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) baud_tick <= slow ? ~baud_tick : 1'b1;

    uart_tx_par i_uart_tx_par (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .baud_tick   (baud_tick),
        .cfg_fmt     (cfg_fmt),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .txd         (txd),
        .buf_empty   (buf_empty),
        .tx_irq      (tx_irq)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // expected payload from the format rules
    task automatic build(input logic [7:0] d, input logic [1:0] f, input logic pe,
                         input logic odd, output logic [8:0] b, output int n);
        b = '0;
        if (f == 2'b00) begin
            b[6:0] = d[6:0]; n = 7;
            if (pe) begin b[7] = (^d[6:0]) ^ odd; n = 8; end
        end else if (f == 2'b01) begin
            b[7:0] = d; n = 8;
            if (pe) begin b[8] = (^d) ^ odd; n = 9; end
        end else begin
            b[7:0] = d; n = 8;
        end
    endtask

    // write on an idle line; returns at the first start-bit cycle
    task automatic put(input logic [7:0] d, input logic [1:0] f, input logic pe, input logic odd);
        wr_en = 1'b1; wr_data = d; cfg_fmt = f; cfg_par_en = pe; cfg_par_odd = odd;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 buf_empty low after write", {8'h0, buf_empty}, 9'h0);
        check("R11 line high before start", {8'h0, txd}, 9'h1);
        @(negedge clk);
        check("R9 buf_empty high after load", {8'h0, buf_empty}, 9'h1);
    endtask

    // called at the first start-bit cycle; returns at the cycle after the end edge
    task automatic expect_frame(input logic [8:0] b, input int n, input int tp, input string tag);
        check({tag, " R2 start edge"}, {8'h0, txd}, 9'h0);
        repeat (8 * tp) @(negedge clk);
        check({tag, " R2 start bit"}, {8'h0, txd}, 9'h0);
        for (int i = 0; i < n; i++) begin
            repeat (16 * tp) @(negedge clk);
            check({tag, " payload bit"}, {8'h0, txd}, {8'h0, b[i]});
        end
        repeat (16 * tp) @(negedge clk);
        check({tag, " R2 stop bit"}, {8'h0, txd}, 9'h1);
        if (tp == 1) begin
            repeat (7) @(negedge clk);
            check({tag, " R8 irq not early"}, {8'h0, tx_irq}, 9'h0);
            @(negedge clk);
            check({tag, " R8 irq at frame end"}, {8'h0, tx_irq}, 9'h1);
        end else begin
            int k = 0;
            while (!tx_irq && k < 20 * tp) begin
                @(negedge clk);
                k++;
            end
            check({tag, " R8 irq seen"}, {8'h0, tx_irq}, 9'h1);
        end
    endtask

    task automatic after_frame(input string tag);
        @(negedge clk);
        check({tag, " R8 irq one cycle"}, {8'h0, tx_irq}, 9'h0);
        check({tag, " R11 idle line"}, {8'h0, txd}, 9'h1);
        check({tag, " R9 buffer empty"}, {8'h0, buf_empty}, 9'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] b;
        logic [8:0] b2;
        int         n;
        int         n2;
        repeat (4) @(negedge clk);
        check("R1 txd in reset", {8'h0, txd}, 9'h1);
        check("R1 buf_empty in reset", {8'h0, buf_empty}, 9'h1);
        check("R1 irq in reset", {8'h0, tx_irq}, 9'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 txd after reset", {8'h0, txd}, 9'h1);
        check("R1 buf_empty after reset", {8'h0, buf_empty}, 9'h1);

        // R11: quiet line with ticks running
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R11 idle txd", {8'h0, txd}, 9'h1);
            check("R11 idle irq", {8'h0, tx_irq}, 9'h0);
        end

        // sweep: every format, parity on/off, even/odd, 32 data patterns (R3 R4 R5 R6)
        for (int f = 0; f < 4; f++) begin
            for (int pe = 0; pe < 2; pe++) begin
                for (int od = 0; od < 2; od++) begin
                    for (int i = 0; i < 32; i++) begin
                        logic [7:0] d;
                        d = 8'(i * 37 + 3);
                        build(d, 2'(f), 1'(pe), 1'(od), b, n);
                        put(d, 2'(f), 1'(pe), 1'(od));
                        expect_frame(b, n, 1, f == 0 ? "R3 R6 sweep" :
                                              f == 1 ? "R4 R6 sweep" : "R5 sweep");
                        after_frame("sweep");
                    end
                end
            end
        end

        // R3: host bit 7 is dropped in 7-bit format without parity
        build(8'hFF, 2'b00, 1'b0, 1'b0, b, n);
        put(8'hFF, 2'b00, 1'b0, 1'b0);
        expect_frame(b, n, 1, "R3 bit7 ignored");
        after_frame("R3");

        // R7: configuration changes after the write do not touch the frame
        build(8'hA5, 2'b01, 1'b1, 1'b0, b, n);
        wr_en = 1'b1; wr_data = 8'hA5; cfg_fmt = 2'b01; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; cfg_fmt = 2'b00; cfg_par_en = 1'b0; cfg_par_odd = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        expect_frame(b, n, 1, "R7 sampled at write");
        after_frame("R7");

        // R2: ticks on every other cycle stretch each bit
        slow = 1'b1;
        build(8'h6C, 2'b01, 1'b1, 1'b1, b, n);
        put(8'h6C, 2'b01, 1'b1, 1'b1);
        expect_frame(b, n, 2, "R2 slow ticks");
        slow = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 slow ticks idle after", {8'h0, txd}, 9'h1);

        // R9 R10: queue a word mid-frame, a third write is dropped
        build(8'h3C, 2'b01, 1'b0, 1'b0, b, n);
        build(8'hC3, 2'b00, 1'b1, 1'b1, b2, n2);
        put(8'h3C, 2'b01, 1'b0, 1'b0);
        fork
            expect_frame(b, n, 1, "R9 first frame");
            begin
                wr_en = 1'b1; wr_data = 8'hC3; cfg_fmt = 2'b00; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
                @(negedge clk);
                wr_data = 8'h5A; cfg_fmt = 2'b01; cfg_par_en = 1'b0;
                @(negedge clk);
                wr_en = 1'b0;
                check("R9 held word keeps buffer full", {8'h0, buf_empty}, 9'h0);
            end
        join
        check("R9 next start in irq cycle", {8'h0, txd}, 9'h0);
        check("R9 buffer drained at hand-off", {8'h0, buf_empty}, 9'h1);
        expect_frame(b2, n2, 1, "R10 held word intact");
        after_frame("R10");
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || tx_irq !== 1'b0)
                check("R10 no third frame", {7'h0, txd, tx_irq}, 9'h2);
        end
        check("R10 line quiet after queue", {7'h0, txd, tx_irq}, 9'h2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule